// File: doc/BRIEF.md
# Three-Direction Disparity Hole Filler

This block repairs a streamed disparity map in which an earlier matching stage has marked unreliable pixels as holes. Pixels arrive in raster order, one per cycle while a line is in flight, with start-of-frame and end-of-line markers. Each pixel leaves the block a fixed number of cycles later in the same format. Valid disparities pass through untouched. A hole is replaced by the smallest of up to three neighbour candidates: the nearest valid pixel to its left on the same line, the nearest valid pixel to its right on the same line, and the nearest valid pixel above it in the same column within the current frame. The smallest disparity is chosen because the background is the most likely owner of an occluded area.

A single one-directional scan unit is instantiated twice. One copy sees each line read back in reverse order and produces the rightward candidates, which are parked per column. The other copy sees the line read forward and produces the leftward candidates, at the same moment the parked rightward and upward candidates are read. A per-column store keeps the most recent valid disparity of each column for the upward direction. A per-frame enable, sampled on the start-of-frame pixel, turns the filling off without changing the latency.

Top module: `hf_fill3`

## Requirements
- R1: A disparity word whose bits are all ones (value -1) is a hole; every other value, negative ones included, is valid and leaves the block unchanged.
- R2: Every accepted pixel appears on the output exactly 2*LINE_W+2 cycles after the clock edge that took it in, with its start-of-frame and end-of-line flags; out_valid is low in every other cycle and after reset.
- R3: With filling enabled, a hole takes the signed minimum of the candidates that exist among the left, right and upward directions.
- R4: The left and right searches stay within the current line: a hole at either end of a line has no candidate from the side beyond that end.
- R5: The upward search reaches any earlier row of the current frame, takes the closest valid pixel in the column, and sees nothing from an earlier frame.
- R6: A hole for which none of the three directions has a valid pixel leaves the block as -1.
- R7: fill_en is sampled on the start-of-frame pixel; when it is 0 the whole frame is passed through unchanged with the same latency.
- R8: A line is LINE_W pixels on consecutive cycles, start-of-frame sits on column 0 of the first line and end-of-line on the last column; any number of idle cycles may separate lines and frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Filling enable, sampled with the start-of-frame pixel |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_eol | input | 1 | Input pixel is the last of its line |
| in_disp | input | DISP_W | Signed input disparity, all ones marks a hole |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_eol | output | 1 | Output pixel is the last of its line |
| out_disp | output | DISP_W | Signed filled disparity |

## Verification
Every result of this block is due 2*LINE_W+2 cycles after its input is taken in: the line is stored, read back reversed for one line time, then read forward for a second, with one register in each scan unit and one at the output. The bench computes the filled frame from whole-frame loops over the stored image and files each expected pixel under the cycle number of its input edge plus that latency, so every cycle's output, idle ones included, is compared against the entry due in that exact cycle. Frames with line gaps, back-to-back frames, holes at line ends, all-hole rows and a bypassed frame place each requirement on its own pixels.

// File: rtl/hf_pkg.sv
package hf_pkg;

    parameter int DISP_W = 9;

    typedef logic signed [DISP_W-1:0] disp_t;

    // a candidate from one search direction
    typedef struct packed {
        logic  has;
        disp_t val;
    } cand_t;

    // sideband carried alongside the forward scan
    typedef struct packed {
        disp_t raw;
        cand_t rc;
        cand_t tc;
        logic  sof;
        logic  eol;
        logic  en;
    } fwd_tag_t;

    localparam disp_t HOLE = '1;

    function automatic cand_t cand_min(cand_t a, cand_t b);
        if (!a.has) return b;
        if (!b.has) return a;
        return (a.val < b.val) ? a : b;
    endfunction

endpackage

// File: rtl/hf_scan.sv
module hf_scan
    import hf_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_first,
    input  disp_t         in_disp,
    input  logic [TW-1:0] in_tag,
    output logic          out_vld,
    output cand_t         out_cand,
    output logic [TW-1:0] out_tag
);

    typedef struct packed {
        cand_t         held;
        logic          vld;
        cand_t         cand;
        logic [TW-1:0] tag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            // candidate offered to the current pixel: strictly earlier pixels
            st_d.cand = in_first ? '0 : st_q.held;
            st_d.tag  = in_tag;
            if (in_disp != HOLE) begin
                st_d.held.has = 1'b1;
                st_d.held.val = in_disp;
            end else if (in_first) begin
                st_d.held = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_cand = st_q.cand;
    assign out_tag  = st_q.tag;

    AST_CAND_NOT_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && out_cand.has |-> out_cand.val != HOLE); // R1
    AST_LINE_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && in_first |=> out_vld && !out_cand.has); // R4

endmodule

// File: rtl/hf_vert.sv
module hf_vert
    import hf_pkg::*;
#(
    parameter int LINE_W = 32,
    localparam int CW = $clog2(LINE_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_vld,
    input  logic [CW-1:0] rd_col,
    input  logic          clear,
    input  disp_t         cur_disp,
    output cand_t         top
);

    typedef struct packed {
        cand_t [LINE_W-1:0] col;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        top  = clear ? '0 : st_q.col[rd_col];
        if (rd_vld) begin
            if (cur_disp != HOLE) begin
                st_d.col[rd_col].has = 1'b1;
                st_d.col[rd_col].val = cur_disp;
            end else if (clear) begin
                st_d.col[rd_col] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TOP_NOT_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld && top.has |-> top.val != HOLE); // R5

endmodule

// File: rtl/hf_fill3.sv
module hf_fill3
    import hf_pkg::*;
#(
    parameter int LINE_W = 32,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [DISP_W-1:0] in_disp,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eol,
    output logic [DISP_W-1:0] out_disp
);

    localparam int CW    = $clog2(LINE_W);
    localparam int SW    = $clog2(SLOTS);
    localparam int RTW   = SW + CW;
    localparam int FTW   = $bits(fwd_tag_t);
    localparam logic [CW-1:0] LAST = CW'(LINE_W - 1);

    typedef struct packed {
        logic [CW-1:0]                  wr_col;
        logic [SW-1:0]                  wr_slot;
        logic                           cur_sof;
        logic                           frame_en;
        disp_t [SLOTS-1:0][LINE_W-1:0]  raw;
        cand_t [SLOTS-1:0][LINE_W-1:0]  rc;
        logic  [SLOTS-1:0]              s_sof;
        logic  [SLOTS-1:0]              s_en;
        logic                           p2_act;
        logic [CW-1:0]                  p2_col;
        logic [SW-1:0]                  p2_slot;
        logic                           pend;
        logic [SW-1:0]                  pend_slot;
        logic                           p3_act;
        logic [CW-1:0]                  p3_col;
        logic [SW-1:0]                  p3_slot;
        logic                           o_vld;
        logic                           o_sof;
        logic                           o_eol;
        disp_t                          o_disp;
    } st_t;

    st_t st_d, st_q;

    // reversed scan (rightward candidates)
    logic           r_vld;
    cand_t          r_cand;
    logic [RTW-1:0] r_tag;
    disp_t          r_in;

    // forward scan (leftward candidates)
    logic           l_vld;
    cand_t          l_cand;
    logic [FTW-1:0] l_tag_bits;
    fwd_tag_t       l_tag;
    fwd_tag_t       f_tag;
    disp_t          f_raw;
    cand_t          top;
    logic           f_clear;

    assign r_in    = st_q.raw[st_q.p2_slot][st_q.p2_col];
    assign f_raw   = st_q.raw[st_q.p3_slot][st_q.p3_col];
    assign f_clear = st_q.s_sof[st_q.p3_slot];
    assign l_tag   = fwd_tag_t'(l_tag_bits);

    always_comb begin
        f_tag     = '0;
        f_tag.raw = f_raw;
        f_tag.rc  = st_q.rc[st_q.p3_slot][st_q.p3_col];
        f_tag.tc  = top;
        f_tag.sof = f_clear && (st_q.p3_col == '0);
        f_tag.eol = (st_q.p3_col == LAST);
        f_tag.en  = st_q.s_en[st_q.p3_slot];
    end

    hf_scan #(.TW(RTW)) u_scan_rev (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (st_q.p2_act),
        .in_first (st_q.p2_col == LAST),
        .in_disp  (r_in),
        .in_tag   ({st_q.p2_slot, st_q.p2_col}),
        .out_vld  (r_vld),
        .out_cand (r_cand),
        .out_tag  (r_tag)
    );

    hf_scan #(.TW(FTW)) u_scan_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (st_q.p3_act),
        .in_first (st_q.p3_col == '0),
        .in_disp  (f_raw),
        .in_tag   (FTW'(f_tag)),
        .out_vld  (l_vld),
        .out_cand (l_cand),
        .out_tag  (l_tag_bits)
    );

    hf_vert #(.LINE_W(LINE_W)) u_vert (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_vld   (st_q.p3_act),
        .rd_col   (st_q.p3_col),
        .clear    (f_clear),
        .cur_disp (f_raw),
        .top      (top)
    );

    always_comb begin
        cand_t best;
        st_d = st_q;

        // capture into the line ring
        if (in_valid) begin
            st_d.raw[st_q.wr_slot][st_q.wr_col] = disp_t'(in_disp);
            if (in_sof) begin
                st_d.cur_sof  = 1'b1;
                st_d.frame_en = fill_en;
            end
            if (in_eol) begin
                st_d.s_sof[st_q.wr_slot] = st_q.cur_sof | in_sof;
                st_d.s_en[st_q.wr_slot]  = in_sof ? fill_en : st_q.frame_en;
                st_d.cur_sof = 1'b0;
                st_d.wr_col  = '0;
                st_d.wr_slot = SW'(st_q.wr_slot + 1'b1);
            end else begin
                st_d.wr_col = CW'(st_q.wr_col + 1'b1);
            end
        end

        // reversed read-back, one line time
        if (st_q.p2_act) begin
            if (st_q.p2_col == '0) st_d.p2_act = 1'b0;
            else                   st_d.p2_col = CW'(st_q.p2_col - 1'b1);
        end
        if (in_valid && in_eol) begin
            st_d.p2_act  = 1'b1;
            st_d.p2_col  = LAST;
            st_d.p2_slot = st_q.wr_slot;
        end

        // park rightward candidates per column
        if (r_vld) begin
            st_d.rc[r_tag[RTW-1:CW]][r_tag[CW-1:0]] = r_cand;
        end

        // forward pass starts once the last parked candidate has landed
        st_d.pend      = st_q.p2_act && (st_q.p2_col == '0);
        st_d.pend_slot = st_q.p2_slot;
        if (st_q.p3_act) begin
            if (st_q.p3_col == LAST) st_d.p3_act = 1'b0;
            else                     st_d.p3_col = CW'(st_q.p3_col + 1'b1);
        end
        if (st_q.pend) begin
            st_d.p3_act  = 1'b1;
            st_d.p3_col  = '0;
            st_d.p3_slot = st_q.pend_slot;
        end

        // minimum and compare
        best        = cand_min(cand_min(l_tag.rc, l_tag.tc), l_cand);
        st_d.o_vld  = l_vld;
        st_d.o_sof  = l_vld && l_tag.sof;
        st_d.o_eol  = l_vld && l_tag.eol;
        if (l_vld) begin
            if (l_tag.en && (l_tag.raw == HOLE) && best.has) st_d.o_disp = best.val;
            else                                             st_d.o_disp = l_tag.raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.o_vld;
    assign out_sof   = st_q.o_sof;
    assign out_eol   = st_q.o_eol;
    assign out_disp  = st_q.o_disp;

    AST_EOL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_eol |-> st_q.wr_col == LAST); // R8
    AST_SOF_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sof |-> st_q.wr_col == '0); // R8
    AST_LINE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_col != '0 |-> in_valid); // R8
    AST_FWD_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> !st_q.p3_act || st_q.p3_col == LAST); // R2
    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        l_vld && !l_tag.en |=> out_valid && out_disp == $past(l_tag.raw)); // R7
    AST_FILL_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        l_vld && l_tag.en && (l_cand.has || l_tag.rc.has || l_tag.tc.has)
        |=> disp_t'(out_disp) != HOLE); // R3
    AST_VALID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        l_vld && l_tag.raw != HOLE |=> out_disp == $past(l_tag.raw)); // R1

endmodule

// File: tb/hf_fill3_bench.sv
`timescale 1ns/1ps
module hf_fill3_bench;
    import hf_pkg::*;

    localparam int LW  = 8;
    localparam int LAT = 2 * LW + 2;
    localparam int MAXR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_en = 1'b0;
    logic in_valid = 1'b0;
    logic in_sof = 1'b0;
    logic in_eol = 1'b0;
    logic [DISP_W-1:0] in_disp = '0;
    logic out_valid, out_sof, out_eol;
    logic [DISP_W-1:0] out_disp;

    always #2 clk = ~clk;

    hf_fill3 #(.LINE_W(LW)) u_hf_fill3 (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_disp(in_disp),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_disp(out_disp)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit run = 1'b0;
    int fr [MAXR][LW];
    int ex [MAXR][LW];
    string rq [MAXR][LW];
    bit    e_v [int];
    int    e_d [int];
    bit    e_s [int];
    bit    e_e [int];
    string e_r [int];
    int seed = 7;

    always @(posedge clk) cyc <= cyc + 1;

    // expected frame from the requirements
    task automatic model(int rows, bit en);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < LW; c++) begin
                int best; bit has; int up; bit uph;
                best = 0; has = 0; uph = 0; up = 0;
                if (fr[r][c] != -1 || !en) begin
                    ex[r][c] = fr[r][c];
                    rq[r][c] = en ? "R1" : "R7";
                    continue;
                end
                for (int k = c - 1; k >= 0; k--) if (fr[r][k] != -1) begin
                    if (!has || fr[r][k] < best) best = fr[r][k];
                    has = 1; break;
                end
                for (int k = c + 1; k < LW; k++) if (fr[r][k] != -1) begin
                    if (!has || fr[r][k] < best) best = fr[r][k];
                    has = 1; break;
                end
                for (int k = r - 1; k >= 0; k--) if (fr[k][c] != -1) begin
                    up = fr[k][c]; uph = 1;
                    if (!has || up < best) best = up;
                    has = 1; break;
                end
                ex[r][c] = has ? best : -1;
                if (!has)                     rq[r][c] = "R6";
                else if (uph && best == up)   rq[r][c] = "R5";
                else if (c == 0 || c == LW-1) rq[r][c] = "R4";
                else                          rq[r][c] = "R3";
            end
        end
    endtask

    task automatic send_frame(int rows, bit en, int gap);
        model(rows, en);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < LW; c++) begin
                int key;
                @(negedge clk);
                in_valid = 1'b1;
                in_sof   = (r == 0 && c == 0);
                in_eol   = (c == LW - 1);
                in_disp  = DISP_W'(fr[r][c]);
                fill_en  = en;
                key = cyc + 1 + LAT;
                e_v[key] = 1'b1; e_d[key] = ex[r][c];
                e_s[key] = in_sof; e_e[key] = in_eol; e_r[key] = rq[r][c];
            end
            for (int g = 0; g < gap + (r % 3); g++) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        if (run) begin
            bit xv; int xd;
            xv = e_v.exists(cyc);
            n_chk++;
            if (out_valid !== xv) begin
                n_bad++;
                $display("FAIL R2 cycle %0d out_valid=%0b expected %0b", cyc, out_valid, xv);
            end else if (xv) begin
                xd = $signed(out_disp);
                if (xd != e_d[cyc]) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d disp=%0d expected %0d", e_r[cyc], cyc, xd, e_d[cyc]);
                end else if (out_sof !== e_s[cyc] || out_eol !== e_e[cyc]) begin
                    n_bad++;
                    $display("FAIL R2 cycle %0d sof/eol=%0b%0b expected %0b%0b",
                             cyc, out_sof, out_eol, e_s[cyc], e_e[cyc]);
                end
            end
        end
    end

    function automatic int lcg();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return seed >> 8;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R2: reset state
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 reset out_valid=%0b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        run = 1'b1;

        // frame A: line-end holes (R4), all-hole row, negative valid value (R1, R3)
        fr[0] = '{-1, -1, 10, -1, 20, -1, -1, -1};
        fr[1] = '{-1, -1, -1, -1, -1, -1, -1, -1};
        fr[2] = '{30, -5, -1, 40, -1, 3, -1, 90};
        fr[3] = '{-1, 50, 60, -1, -1, -1, 70, -1};
        send_frame(4, 1'b1, 0);

        // frame B: pseudo-random holes with idle gaps between lines (R3, R8)
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < LW; c++)
                fr[r][c] = (lcg() % 5 < 2) ? -1 : (lcg() % 200);
        send_frame(6, 1'b1, 3);

        // frame C: back-to-back, row 0 all holes; nothing may come from frame B (R5, R6)
        for (int c = 0; c < LW; c++) fr[0][c] = -1;
        fr[1] = '{-1, 12, -1, -1, 8, -1, -1, -1};
        fr[2] = '{-1, -1, -1, 2, -1, -1, 100, -1};
        send_frame(3, 1'b1, 0);

        // frame D: filling disabled, holes must pass through (R7)
        fr[0] = '{-1, -1, 10, -1, 20, -1, -1, -1};
        fr[1] = '{5, -1, -1, -1, -1, -1, -1, 6};
        send_frame(2, 1'b0, 1);

        // frame E: enabled again, long gaps (R3, R8)
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < LW; c++)
                fr[r][c] = (lcg() % 3 == 0) ? -1 : (lcg() % 250) - 20;
        send_frame(5, 1'b1, 7);

        repeat (LAT + 6) @(negedge clk);
        run = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog expired at cycle %0d", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule